// File: doc/BRIEF.md
# Push-Button Frequency Setter with Square-Wave Output

This block holds an 8-bit frequency setting, in units of a parameterised step frequency (1 kHz by default), and turns it into a square wave made from the system clock. Two push buttons, one raising and one lowering the setting, adjust the value. A short press moves the setting by one. A press held past the hold time (one second by default) keeps stepping the setting in that direction at a fixed repeat rate until the button is let go. The setting is always visible in binary on an 8-bit LED output.

Each raw button goes through a two-flop synchroniser and a debounce filter before the control logic sees it. The control logic turns debounced levels into one-cycle step strobes. The datapath applies those strobes to a saturating setting register. A phase accumulator, advanced by the setting times a fixed increment on every clock, produces the wave. All cycle counts come from the system clock frequency parameter.

Top module: `btn_square_gen`

## Requirements
- R1: A synchronous reset, taken while `rstN` is low, sets the setting to 1, clears the phase accumulator so the wave is low, and returns the button controller to idle.
- R2: `ledOut` always shows the current setting in binary, with LED bit i equal to setting bit i.
- R3: A button input (active high, 1 = pressed) passes through two synchronising flops. Its debounced level changes only after the synchronised input has differed from it for DEBOUNCE_US microseconds of clock cycles in a row. A shorter pulse has no effect on the setting.
- R4: A debounced press of `btnUp` adds exactly one to the setting as soon as it is recognised. If it is released before the hold time, no further step follows.
- R5: A debounced press of `btnDown` subtracts exactly one from the setting in the same way.
- R6: Once one button alone has stayed pressed for HOLD_MS milliseconds of cycles, the setting steps once more in that direction. It then steps again every CLK_HZ/REPEAT_PER_SEC cycles, and stepping stops when the button's debounced level falls.
- R7: The setting saturates. An increase at 255 leaves it at 255, a decrease at 0 leaves it at 0, and it never wraps.
- R8: On every clock, an ACC_W-bit phase accumulator adds setting × round(UNIT_HZ·2^ACC_W/CLK_HZ), modulo 2^ACC_W. `waveOut` is the accumulator's top bit, which gives a square wave of about setting × UNIT_HZ hertz with roughly even duty.
- R9: While the setting is 0, `waveOut` stays low and the accumulator does not move.
- R10: If both debounced buttons are high at the same time, no step is produced. The controller then ignores both buttons until both have been released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rstN | input | 1 | Synchronous reset, active low |
| btnUp | input | 1 | Raw increase button, high when pressed |
| btnDown | input | 1 | Raw decrease button, high when pressed |
| ledOut | output | 8 | Current setting in binary |
| waveOut | output | 1 | Square-wave output |

## Verification
Some properties are checked on every cycle. These are the saturation limits, the single-unit size of every setting change, the frozen accumulator at a setting of zero, the absence of strobes while both buttons are down or after a release, and the debounced level only ever taking the value the synchroniser offered. Other behaviour only shows up in the bench's scenarios: the press-versus-hold split, the repeat cadence, rejection of short glitches, and whether the wave's edge count over one simulated second matches the setting. The bench covers these by running a behavioural cycle model next to the design and comparing the LED and wave outputs on every clock, with targeted end-state checks besides.

// File: rtl/sqgen_pkg.sv
`timescale 1ns/1ps
package sqgen_pkg;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepCmd_t;

  typedef enum logic [1:0] {
    CTL_IDLE    = 2'd0,
    CTL_HOLD    = 2'd1,
    CTL_REPEAT  = 2'd2,
    CTL_BLOCKED = 2'd3
  } ctlState_t;

endpackage

// File: rtl/sqgen_btn_filter.sv
`timescale 1ns/1ps
module sqgen_btn_filter #(
  parameter int DEB_CYC = 500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic debOut
);
  localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC + 1) : 1;

  logic syncA;
  logic syncB;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA  <= 1'b0;
      syncB  <= 1'b0;
      debOut <= 1'b0;
      runCnt <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      if (syncB == debOut) begin
        runCnt <= '0;
      end else if (runCnt == CW'(DEB_CYC - 1)) begin
        debOut <= syncB;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  // R3: the filtered level only ever takes the synchronised value
  assert_filter_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(debOut) |-> (debOut == $past(syncB)));

  // R3: no change while the synchronised input agrees
  assert_filter_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (syncB == debOut) |=> $stable(debOut));

endmodule

// File: rtl/sqgen_ctrl.sv
`timescale 1ns/1ps
module sqgen_ctrl
  import sqgen_pkg::*;
#(
  parameter int CLK_HZ         = 50000000,
  parameter int DEBOUNCE_US    = 10000,
  parameter int HOLD_MS        = 1000,
  parameter int REPEAT_PER_SEC = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] btnRaw,
  output stepCmd_t   cmd
);
  localparam int DEB_CYC  = int'((longint'(CLK_HZ) * longint'(DEBOUNCE_US)) / 64'd1000000);
  localparam int HOLD_CYC = int'((longint'(CLK_HZ) * longint'(HOLD_MS)) / 64'd1000);
  localparam int REP_CYC  = CLK_HZ / REPEAT_PER_SEC;
  localparam int CNT_W    = $clog2(HOLD_CYC + 1);

  logic [1:0] debBtn;

  for (genvar i = 0; i < 2; i++) begin : g_filt
    sqgen_btn_filter #(.DEB_CYC(DEB_CYC)) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (btnRaw[i]),
      .debOut (debBtn[i])
    );
  end

  logic upLvl;
  logic dnLvl;
  logic activeLvl;
  assign upLvl     = debBtn[0];
  assign dnLvl     = debBtn[1];

  ctlState_t  state;
  logic       dirUp;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] limitCnt;

  assign activeLvl = dirUp ? upLvl : dnLvl;
  assign limitCnt  = (state == CTL_HOLD) ? CNT_W'(HOLD_CYC - 1) : CNT_W'(REP_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= CTL_IDLE;
      dirUp   <= 1'b0;
      tickCnt <= '0;
      cmd     <= '0;
    end else begin
      cmd <= '0;
      case (state)
        CTL_IDLE: begin
          tickCnt <= '0;
          if (upLvl && dnLvl) begin
            state <= CTL_BLOCKED;
          end else if (upLvl || dnLvl) begin
            state        <= CTL_HOLD;
            dirUp        <= upLvl;
            cmd.stepUp   <= upLvl;
            cmd.stepDown <= dnLvl;
          end
        end
        CTL_HOLD, CTL_REPEAT: begin
          if (upLvl && dnLvl) begin
            state   <= CTL_BLOCKED;
            tickCnt <= '0;
          end else if (!activeLvl) begin
            state   <= CTL_IDLE;
            tickCnt <= '0;
          end else if (tickCnt == limitCnt) begin
            state        <= CTL_REPEAT;
            tickCnt      <= '0;
            cmd.stepUp   <= dirUp;
            cmd.stepDown <= !dirUp;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        CTL_BLOCKED: begin
          if (!upLvl && !dnLvl) state <= CTL_IDLE;
        end
        default: state <= CTL_IDLE;
      endcase
    end
  end

  // R10: never both strobes in one cycle
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.stepUp && cmd.stepDown));

  // R10: both buttons down yields no step
  assert_both_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (upLvl && dnLvl) |=> (!cmd.stepUp && !cmd.stepDown));

  // R6: released buttons stop all stepping
  assert_release_stops_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!upLvl && !dnLvl) |=> (!cmd.stepUp && !cmd.stepDown));

endmodule

// File: rtl/sqgen_datapath.sv
`timescale 1ns/1ps
module sqgen_datapath
  import sqgen_pkg::*;
#(
  parameter int CLK_HZ  = 50000000,
  parameter int UNIT_HZ = 1000,
  parameter int ACC_W   = 24,
  parameter int SET_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCmd_t         cmd,
  output logic [SET_W-1:0] setting,
  output logic             waveOut
);
  localparam longint unsigned UNIT_CALC =
    (longint'(UNIT_HZ) * (longint'(1) << ACC_W) + longint'(CLK_HZ / 2)) / longint'(CLK_HZ);
  localparam logic [ACC_W-1:0] STEP_UNIT = UNIT_CALC[ACC_W-1:0];
  localparam logic [SET_W-1:0] SET_MAX   = '1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] incr;

  assign incr = STEP_UNIT * ACC_W'(setting);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setting <= SET_W'(1);
      acc     <= '0;
    end else begin
      acc <= acc + incr;
      if (cmd.stepUp && (setting != SET_MAX)) begin
        setting <= setting + 1'b1;
      end else if (cmd.stepDown && (setting != '0)) begin
        setting <= setting - 1'b1;
      end
    end
  end

  assign waveOut = acc[ACC_W-1] && (setting != '0);

  // R7: increase at the top is absorbed
  assert_sat_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp && setting == SET_MAX) |=> (setting == SET_MAX));

  // R7: decrease at zero is absorbed
  assert_sat_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepDown && setting == '0) |=> (setting == '0));

  // R4: an accepted increase moves by exactly one
  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp && setting != SET_MAX) |=> (setting == $past(setting) + SET_W'(1)));

  // R5: any change of the setting is one unit
  assert_unit_change_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(setting) |-> ((SET_W'(setting - $past(setting)) == SET_W'(1)) ||
                           (SET_W'($past(setting) - setting) == SET_W'(1))));

  // R9: a zero setting freezes the accumulator
  assert_zero_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    (setting == '0) |=> $stable(acc));

  // R8: a nonzero setting always advances the phase
  assert_acc_moves_R8: assert property (@(posedge clk) disable iff (!rstN)
    (setting != '0) |=> !$stable(acc));

endmodule

// File: rtl/btn_square_gen.sv
`timescale 1ns/1ps
module btn_square_gen
  import sqgen_pkg::*;
#(
  parameter int CLK_HZ         = 50000000,
  parameter int UNIT_HZ        = 1000,
  parameter int DEBOUNCE_US    = 10000,
  parameter int HOLD_MS        = 1000,
  parameter int REPEAT_PER_SEC = 10,
  parameter int ACC_W          = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       btnUp,
  input  logic       btnDown,
  output logic [7:0] ledOut,
  output logic       waveOut
);
  localparam int SET_W = 8;

  stepCmd_t         stepCmd;
  logic [SET_W-1:0] setting;

  sqgen_ctrl #(
    .CLK_HZ         (CLK_HZ),
    .DEBOUNCE_US    (DEBOUNCE_US),
    .HOLD_MS        (HOLD_MS),
    .REPEAT_PER_SEC (REPEAT_PER_SEC)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .btnRaw ({btnDown, btnUp}),
    .cmd    (stepCmd)
  );

  sqgen_datapath #(
    .CLK_HZ  (CLK_HZ),
    .UNIT_HZ (UNIT_HZ),
    .ACC_W   (ACC_W),
    .SET_W   (SET_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (stepCmd),
    .setting (setting),
    .waveOut (waveOut)
  );

  assign ledOut = setting;

endmodule

// File: tb/btn_square_gen_tb_top.sv
`timescale 1ns/1ps
module btn_square_gen_tb_top;
  localparam int CLK_HZ = 4000;
  localparam int UNIT_HZ = 1;
  localparam int ACC_W = 24;
  localparam int DEB = 40;    // 10 ms at CLK_HZ
  localparam int HOLD = 4000; // 1 s
  localparam int REP = 40;    // 100 steps per second
  localparam int UNIT = (UNIT_HZ * (1 << ACC_W) + CLK_HZ / 2) / CLK_HZ;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic btnUp = 1'b0;
  logic btnDown = 1'b0;
  logic [7:0] ledOut;
  logic waveOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  btn_square_gen #(
    .CLK_HZ(CLK_HZ), .UNIT_HZ(UNIT_HZ), .DEBOUNCE_US(10000),
    .HOLD_MS(1000), .REPEAT_PER_SEC(100), .ACC_W(ACC_W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .btnUp(btnUp), .btnDown(btnDown),
    .ledOut(ledOut), .waveOut(waveOut)
  );

  // behavioural reference model
  bit mS1 [2];
  bit mS2 [2];
  bit mDeb [2];
  int mDc [2];
  int mState;
  int mCnt;
  bit mDirUp;
  bit mUpStr;
  bit mDnStr;
  int mSet = 1;
  logic [ACC_W-1:0] mAcc = '0;
  bit modelLive = 0;

  always @(posedge clk) begin
    bit up, dn, act, nUp, nDn;
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin mS1[i] = 0; mS2[i] = 0; mDeb[i] = 0; mDc[i] = 0; end
      mState = 0; mCnt = 0; mDirUp = 0; mUpStr = 0; mDnStr = 0;
      mSet = 1; mAcc = '0;
      modelLive = 1;
    end else begin
      mAcc = mAcc + ACC_W'(mSet * UNIT);
      if (mUpStr && mSet < 255) mSet = mSet + 1;
      else if (mDnStr && mSet > 0) mSet = mSet - 1;
      up = mDeb[0]; dn = mDeb[1]; nUp = 0; nDn = 0;
      act = mDirUp ? up : dn;
      case (mState)
        0: begin
          mCnt = 0;
          if (up && dn) mState = 3;
          else if (up || dn) begin mState = 1; mDirUp = up; nUp = up; nDn = dn; end
        end
        1, 2: begin
          if (up && dn) begin mState = 3; mCnt = 0; end
          else if (!act) begin mState = 0; mCnt = 0; end
          else if (mCnt == ((mState == 1) ? HOLD : REP) - 1) begin
            mState = 2; mCnt = 0; nUp = mDirUp; nDn = !mDirUp;
          end else mCnt = mCnt + 1;
        end
        default: if (!up && !dn) mState = 0;
      endcase
      mUpStr = nUp; mDnStr = nDn;
      for (int i = 0; i < 2; i++) begin
        if (mS2[i] == mDeb[i]) mDc[i] = 0;
        else if (mDc[i] == DEB - 1) begin mDeb[i] = mS2[i]; mDc[i] = 0; end
        else mDc[i] = mDc[i] + 1;
      end
      mS2[0] = mS1[0]; mS2[1] = mS1[1];
      mS1[0] = btnUp; mS1[1] = btnDown;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (modelLive && !done) begin
      checks++;
      if (ledOut !== 8'(mSet)) begin
        failures++;
        $display("FAIL R2 model led actual=%0d expected=%0d t=%0t", ledOut, mSet, $time);
      end
      checks++;
      if (waveOut !== ((mSet != 0) && mAcc[ACC_W-1])) begin
        failures++;
        $display("FAIL R8 model wave actual=%0b expected=%0b t=%0t", waveOut,
                 ((mSet != 0) && mAcc[ACC_W-1]), $time);
      end
    end
  end

  task automatic checkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkRange(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tapUp(int n);
    btnUp = 1'b1; waitCyc(n); btnUp = 1'b0; waitCyc(200);
  endtask

  task automatic tapDown(int n);
    btnDown = 1'b1; waitCyc(n); btnDown = 1'b0; waitCyc(200);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int edges;
    int base;
    int held;
    bit prevW;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(2);
    checkEq("R1 reset setting", ledOut, 1);
    checkEq("R1 reset wave", waveOut, 0);

    tapUp(200);
    checkEq("R4 short up press", ledOut, 2);
    tapDown(200);
    checkEq("R5 short down press", ledOut, 1);
    tapDown(200);
    checkEq("R5 down to zero", ledOut, 0);

    edges = 0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (waveOut) edges++;
    end
    checkEq("R9 wave low at zero", edges, 0);

    tapDown(200);
    checkEq("R7 decrease at zero", ledOut, 0);

    tapUp(20);
    checkEq("R3 short glitch ignored", ledOut, 0);

    btnUp = 1'b1; btnDown = 1'b1; waitCyc(300);
    btnUp = 1'b0; btnDown = 1'b0; waitCyc(200);
    checkEq("R10 both pressed ignored", ledOut, 0);

    for (int k = 0; k < 5; k++) tapUp(100);
    checkEq("R2 led binary 5", ledOut, 8'b0000_0101);

    edges = 0;
    prevW = waveOut;
    for (int k = 0; k < CLK_HZ; k++) begin
      @(negedge clk);
      if (waveOut && !prevW) edges++;
      prevW = waveOut;
    end
    checkRange("R8 edges in one second", edges, 4, 6);

    base = ledOut;
    btnUp = 1'b1; waitCyc(HOLD + 400); btnUp = 1'b0;
    waitCyc(200);
    checkRange("R6 auto repeat after hold", ledOut, base + 5, base + 14);
    held = ledOut;
    waitCyc(300);
    checkEq("R6 stepping stops on release", ledOut, held);

    btnUp = 1'b1; waitCyc(15000); btnUp = 1'b0; waitCyc(200);
    checkEq("R7 saturate at top", ledOut, 255);

    btnDown = 1'b1; waitCyc(15000); btnDown = 1'b0; waitCyc(200);
    checkEq("R7 saturate at bottom", ledOut, 0);
    checkEq("R9 wave low after ramp down", waveOut, 0);

    tapUp(200); tapUp(200); tapUp(200);
    @(negedge clk); rstN = 1'b0;
    waitCyc(3); rstN = 1'b1; waitCyc(2);
    checkEq("R1 reset mid run", ledOut, 1);

    finishRun();
  end
endmodule